// File: doc/BRIEF.md
# Big-endian operand word packer

This block turns a big integer that arrives as a byte stream, most significant byte first, into a run of 64-bit words written into a word-addressed RAM. The least significant word goes to the lowest address. The caller supplies the byte count, a base address and a modulus bit length with each request.

The number of words written depends only on the modulus length: one word for every started 64 bits of the modulus, plus one extra word that is always zero. Bytes missing above the supplied data are written as zero. Because the first byte to arrive is the most significant one, the whole operand is collected in an internal buffer before any word is written.

A request is refused when the data cannot fit below the zero guard word, or when the word count is larger than the limit for a 640-bit operand. A refused request writes nothing and consumes no byte.

Top module: `operand_word_packer`

## Requirements
- R1: An accepted request with modulus length M bits writes exactly ceil(M/64)+1 words, on consecutive cycles.
- R2: In each written word, byte lane k (bits 8k+7:8k) holds the byte that came k+8w positions before the last byte of the stream, where w is the word index. The last byte received therefore lands in bits 7:0 of word 0.
- R3: Word w is written to address base+w, and the words are written in rising order starting with word 0.
- R4: Lanes above the byte count are written as zero. Every word past the data is zero, and the final word written is always zero.
- R5: A request whose byte count N satisfies ceil(N/8)+1 > ceil(M/64)+1 is refused. The block pulses err together with done, makes no RAM write and takes no byte from the stream.
- R6: A request whose word count ceil(M/64)+1 is larger than MAX_WORDS (11) is refused in the same way. A count of exactly 11 is accepted.
- R7: done is a single-cycle pulse. After an accepted request it comes one cycle after the cycle holding the last write, with err low. After a refused request it comes in the cycle after the request, with err high.
- R8: req_ready is low from the acceptance of a request until done. in_ready is high only while bytes are still owed, and exactly N bytes are taken from the stream.
- R9: With a byte count of zero, no byte is taken from the stream and every word written is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_bytes | input | CNT_W | Number of operand bytes N |
| req_base | input | ADDR_W | RAM address of word 0 |
| req_mod_bits | input | LEN_W | Modulus length M in bits |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Block takes a stream byte |
| in_data | input | 8 | Stream byte, most significant first |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | WORD_W | RAM write data |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request refused (one cycle, with done) |

## Verification
The assertions assume that every request is presented only while req_ready is high, and is held for exactly one cycle. They also assume that a request whose stream is still being loaded always receives its N bytes eventually. The stimulus raises req_valid for a single cycle after it has seen the block idle. It offers bytes only for accepted requests, and it stops offering them once N bytes have been taken. In refused cases it deliberately holds in_valid high, to show that no byte is taken.

// File: rtl/op_pack_pkg.sv
package op_pack_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_EMIT,
    ST_FIN
  } pack_state_t;
endpackage

// File: rtl/op_size_check.sv
// Works out the operand word count from the modulus length and decides
// whether the request can be served.
module op_size_check #(
  parameter int WORD_W    = 64,
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 8,
  parameter int MAX_WORDS = 11,
  parameter int NBW_W     = 6
) (
  input  logic [LEN_W-1:0] mod_bits,
  input  logic [CNT_W-1:0] nbytes,
  output logic [NBW_W-1:0] nbw,
  output logic             ok
);
  localparam int LANES  = WORD_W / op_pack_pkg::BYTE_W;
  localparam int WSHIFT = $clog2(WORD_W);
  localparam int BSHIFT = $clog2(LANES);

  logic [LEN_W:0]   mod_round;
  logic [CNT_W:0]   byte_round;
  logic [NBW_W-1:0] mod_words;
  logic [NBW_W-1:0] data_words;

  always_comb begin
    mod_round  = {1'b0, mod_bits} + (LEN_W+1)'(WORD_W - 1);
    byte_round = {1'b0, nbytes} + (CNT_W+1)'(LANES - 1);
    mod_words  = NBW_W'(mod_round >> WSHIFT);
    data_words = NBW_W'(byte_round >> BSHIFT);
    nbw        = mod_words + NBW_W'(1);
    // R5: data plus the guard word must fit; R6: hard word limit
    ok         = (nbw <= NBW_W'(MAX_WORDS)) && ((data_words + NBW_W'(1)) <= nbw);
  end
endmodule

// File: rtl/op_byte_buffer.sv
// Byte store indexed by significance (0 = least significant); the read
// side assembles one word, zero-filling lanes at or above the byte count.
module op_byte_buffer #(
  parameter int LANES  = 8,
  parameter int DEPTH  = 80,
  parameter int IDX_W  = 7,
  parameter int CNT_W  = 8,
  parameter int WSEL_W = 4
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_byte,
  input  logic [WSEL_W-1:0]     rd_word,
  input  logic [CNT_W-1:0]      nbytes,
  output logic [LANES*8-1:0]    rd_data
);
  localparam int P_W = CNT_W + WSEL_W + 4;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_byte;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [P_W-1:0] pos;
    logic           live;
    assign pos  = P_W'(rd_word) * P_W'(LANES) + P_W'(j);
    assign live = (pos < P_W'(nbytes)) && (pos < P_W'(DEPTH));
    // R2 lane k of word w holds significance 8w+k; R4 zero above count
    assign rd_data[8*j +: 8] = live ? mem[IDX_W'(pos)] : 8'h00;
  end
endmodule

// File: rtl/operand_word_packer.sv
module operand_word_packer #(
  parameter int WORD_W    = 64,
  parameter int MAX_WORDS = 11,
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [LEN_W-1:0]  req_mod_bits,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic              done,
  output logic              err
);
  import op_pack_pkg::*;

  localparam int LANES     = WORD_W / BYTE_W;
  localparam int BUF_BYTES = (MAX_WORDS - 1) * LANES;
  localparam int IDX_W     = $clog2(BUF_BYTES);
  localparam int WSEL_W    = $clog2(MAX_WORDS);
  localparam int NBW_W     = $clog2(((1 << LEN_W) + WORD_W - 1) / WORD_W + 2);

  pack_state_t       state;
  logic [NBW_W-1:0]  nbw_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  bytes_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  left_m1;
  logic [WSEL_W-1:0] wsel_q;
  logic [NBW_W-1:0]  chk_nbw;
  logic              chk_ok;
  logic [WORD_W-1:0] word_rd;
  logic              take;
  logic              last_word;

  assign req_ready = (state == ST_IDLE);
  assign in_ready  = (state == ST_LOAD);
  assign take      = in_valid && in_ready;
  assign left_m1   = left_q - CNT_W'(1);
  assign last_word = (NBW_W'(wsel_q) == (nbw_q - NBW_W'(1)));

  op_size_check #(
    .WORD_W(WORD_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .MAX_WORDS(MAX_WORDS), .NBW_W(NBW_W)
  ) i_size (
    .mod_bits(req_mod_bits),
    .nbytes  (req_bytes),
    .nbw     (chk_nbw),
    .ok      (chk_ok)
  );

  op_byte_buffer #(
    .LANES(LANES), .DEPTH(BUF_BYTES), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .WSEL_W(WSEL_W)
  ) i_buf (
    .clk    (clk),
    .wr_en  (take),
    .wr_idx (IDX_W'(left_m1)),
    .wr_byte(in_data),
    .rd_word(wsel_q),
    .nbytes (bytes_q),
    .rd_data(word_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      nbw_q     <= '0;
      base_q    <= '0;
      bytes_q   <= '0;
      left_q    <= '0;
      wsel_q    <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (chk_ok) begin
              nbw_q   <= chk_nbw;
              base_q  <= req_base;
              bytes_q <= req_bytes;
              left_q  <= req_bytes;
              wsel_q  <= '0;
              // R9: an empty operand skips loading
              state   <= (req_bytes == '0) ? ST_EMIT : ST_LOAD;
            end else begin
              err  <= 1'b1;
              done <= 1'b1;
            end
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            left_q <= left_m1;
            if (left_q == CNT_W'(1)) state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          ram_we    <= 1'b1;
          ram_addr  <= base_q + ADDR_W'(wsel_q);
          ram_wdata <= word_rd;
          wsel_q    <= wsel_q + WSEL_W'(1);
          if (last_word) state <= ST_FIN;
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // Checking aid: writes since the last accepted request
  logic [NBW_W-1:0] wr_cnt;
  always_ff @(posedge clk) begin
    if (rst) wr_cnt <= '0;
    else if (state == ST_IDLE && req_valid && chk_ok) wr_cnt <= '0;
    else if (ram_we) wr_cnt <= wr_cnt + NBW_W'(1);
  end

  a_r1_word_count: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (wr_cnt == nbw_q));

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + ADDR_W'(1)));

  a_r4_guard_zero: assert property (@(posedge clk) disable iff (rst)
    (!ram_we && $past(ram_we)) |-> ($past(ram_wdata) == '0));

  a_r5_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !$past(ram_we)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> $past(ram_we));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (!in_ready && !req_ready));
endmodule

// File: tb/test_operand_word_packer.sv
module test_operand_word_packer;
  localparam int WORD_W = 64;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 11;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CNT_W-1:0]  req_bytes = '0;
  logic [ADDR_W-1:0] req_base = '0;
  logic [LEN_W-1:0]  req_mod_bits = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [WORD_W-1:0] ram_wdata;
  logic done, err;

  always #5 clk = ~clk;

  operand_word_packer i_operand_word_packer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bytes(req_bytes), .req_base(req_base), .req_mod_bits(req_mod_bits),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .done(done), .err(err)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] src [0:127];
  logic [ADDR_W-1:0] cap_addr [0:31];
  logic [WORD_W-1:0] cap_data [0:31];
  int n_wr, n_done, n_err, cyc, last_wr_cyc, done_cyc;

  always @(negedge clk) begin
    cyc++;
    if (ram_we) begin
      if (n_wr < 32) begin
        cap_addr[n_wr] = ram_addr;
        cap_data[n_wr] = ram_wdata;
      end
      n_wr++;
      last_wr_cyc = cyc;
    end
    if (done) begin
      n_done++;
      done_cyc = cyc;
      if (err) n_err++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] exp_word(input int w, input int n);
    logic [WORD_W-1:0] v = '0;
    for (int j = 0; j < 8; j++) begin
      int p = w * 8 + j;
      if (p < n) v[8*j +: 8] = src[n-1-p];
    end
    return v;
  endfunction

  task automatic fill(input int n, input int seed);
    for (int k = 0; k < 128; k++) src[k] = 8'(k * 37 + seed * 11 + 1);
    if (n > 0) src[0] = 8'hA5;
  endtask

  task automatic run_op(input string tag, input int nbytes, input int mbits,
                        input int base, input bit gaps);
    int nbw = (mbits + 63) / 64 + 1;
    bit ok = (nbw <= 11) && (((nbytes + 7) / 8 + 1) <= nbw);
    int wd = 0;
    bit saw_in_ready = 1'b0;
    n_wr = 0; n_done = 0; n_err = 0;
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    req_bytes = CNT_W'(nbytes);
    req_base = ADDR_W'(base);
    req_mod_bits = LEN_W'(mbits);
    req_valid = 1'b1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    if (ok) begin
      check(req_ready == 1'b0, "R8", {tag, " req_ready while busy"}, req_ready, 0);
      for (int k = 0; k < nbytes; k++) begin
        if (gaps && (k % 3 == 1)) begin @(negedge clk); #1; end
        while (!in_ready && wd < 50) begin @(negedge clk); #1; wd++; end
        in_data = src[k];
        in_valid = 1'b1;
        @(negedge clk); #1;
        in_valid = 1'b0;
      end
      check(in_ready == 1'b0, "R8", {tag, " in_ready after N bytes"}, in_ready, 0);
    end else begin
      in_valid = 1'b1;
      for (int k = 0; k < 4; k++) begin
        if (in_ready) saw_in_ready = 1'b1;
        @(negedge clk); #1;
      end
      in_valid = 1'b0;
      check(!saw_in_ready, "R5", {tag, " byte taken on refusal"}, saw_in_ready, 0);
    end
    wd = 0;
    while (n_done == 0 && wd < 200) begin @(negedge clk); #1; wd++; end
    repeat (3) @(negedge clk);
    #1;
    check(n_done == 1, "R7", {tag, " done pulses"}, n_done, 1);
    if (ok) begin
      check(n_err == 0, "R7", {tag, " err on accepted"}, n_err, 0);
      check(n_wr == nbw, "R1", {tag, " word count"}, n_wr, nbw);
      check(done_cyc == last_wr_cyc + 1, "R7", {tag, " done timing"},
            done_cyc - last_wr_cyc, 1);
      for (int w = 0; w < nbw && w < 32; w++) begin
        check(cap_addr[w] == ADDR_W'(base + w), "R3", {tag, " address"},
              cap_addr[w], ADDR_W'(base + w));
        check(cap_data[w] == exp_word(w, nbytes), "R2", {tag, " word data"},
              cap_data[w], exp_word(w, nbytes));
      end
      check(cap_data[nbw-1] == '0, "R4", {tag, " guard word"}, cap_data[nbw-1], 0);
    end else begin
      check(n_err == 1, "R5", {tag, " err pulse"}, n_err, 1);
      check(n_wr == 0, "R6", {tag, " writes on refusal"}, n_wr, 0);
    end
  endtask

  task automatic t_reset;
    check(ram_we == 1'b0 && done == 1'b0 && err == 1'b0, "R7", "reset outputs",
          {ram_we, done, err}, 0);
    check(req_ready == 1'b1 && in_ready == 1'b0, "R8", "reset handshakes",
          {req_ready, in_ready}, 2);
  endtask

  task automatic t_full_words;  fill(32, 1); run_op("full", 32, 256, 16'h0100, 1'b0); endtask
  task automatic t_partial;     fill(3, 2);  run_op("partial R4", 3, 256, 16'h0200, 1'b0); endtask
  task automatic t_odd_modulus; fill(66, 3); run_op("m521", 66, 521, 16'h03F0, 1'b1); endtask
  task automatic t_empty;       fill(0, 4);  run_op("empty R9", 0, 64, 16'h0040, 1'b0); endtask
  task automatic t_limit;       fill(80, 5); run_op("limit R6", 80, 640, 16'h0800, 1'b1); endtask
  task automatic t_no_fit;      fill(33, 6); run_op("nofit R5", 33, 256, 16'h0100, 1'b0); endtask
  task automatic t_too_big;     fill(8, 7);  run_op("big R6", 8, 641, 16'h0100, 1'b0); endtask
  task automatic t_recover;     fill(9, 8);  run_op("recover", 9, 65, 16'hFFFE, 1'b1); endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_full_words();
    t_partial();
    t_odd_modulus();
    t_empty();
    t_limit();
    t_no_fit();
    t_too_big();
    t_recover();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule